// File: doc/BRIEF.md
# Serial Receive Character Queue with Error Tracking

This block sits between a serial receiver's shift register and the host. Each assembled character arrives with three error tags (parity, framing, break). It goes into a three-slot holding queue. When the queue is full, the shift stage keeps one more character, so the receive path has four stages of buffering. The host pops the oldest character through a read strobe. It watches a set of status pins: ready, full, the error tags, and overrun. One interrupt line follows either ready or full, as a pin selects.

The error pins work in one of two modes. In per-character mode they show the tags of the character at the head of the queue. In block mode they show a sticky OR of the tags of every character that has reached the head since the last error-clear command. The block mode lets software check a whole message once, at its end. A separate flow-control output drops when a start bit is seen while the queue is full. It rises again once a slot is free.

The character input has no ready signal, on purpose. Characters arrive at line rate and cannot be held back. When the queue and the shift stage are both occupied, a new character replaces the one waiting in the shift stage. The flow-control output is the only means of back-pressure. The host side is a plain read strobe. A strobe on an empty queue does nothing.

Top module: `rx_char_fifo`

## Requirements
- R1: After reset, ready, full, irq, overrun and all error pins are 0, rts is 1 and rd_data is 0.
- R2: Characters leave in arrival order; rd_data takes the head character on the clock edge that samples rd_strobe and holds it until the next successful read.
- R3: stat_ready is 1 while at least one character is queued; stat_full is 1 while all three slots are used; irq follows stat_full when irq_on_full is 1, otherwise stat_ready.
- R4: A character that completes while the queue is full waits in the shift stage; on a read it moves into the queue in the same cycle, so stat_full stays 1 and the character is read later in order.
- R5: When a character arrives while one is already waiting and the queue is full with no read, the waiting character is lost and the queue contents are unchanged.
- R6: stat_ovr sets on a start_det pulse while a character waits in the shift stage, the queue is full and no read occurs; it stays set until err_reset or rx_reset.
- R7: With block_mode 0, stat_err shows the tags of the head character (bit 0 parity, bit 1 framing, bit 2 break) and is 0 when the queue is empty.
- R8: With block_mode 1, stat_err is the OR of the tags of every character that has become head since the last err_reset; err_reset clears these bits and stat_ovr without changing the queue.
- R9: With auto_rts 1, rts drops to 0 after a start_det while the queue is full and not being read, and returns to 1 once the queue holds fewer than three characters; with auto_rts 0, rts is 1.
- R10: While the receiver is off (after rx_dis_cmd), char_valid is ignored, but queued characters can still be read.
- R11: rx_reset empties the queue and the shift stage, clears all status, deasserts irq, drives rts to 1 and turns the receiver off until rx_en_cmd.
- R12: A read strobe on an empty queue leaves rd_data and the queue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en_cmd | input | 1 | Pulse: turn the receiver on |
| rx_dis_cmd | input | 1 | Pulse: turn the receiver off |
| rx_reset | input | 1 | Pulse: receiver reset |
| err_reset | input | 1 | Pulse: clear overrun and accumulated tags |
| block_mode | input | 1 | 1 = sticky block status, 0 = per-character |
| irq_on_full | input | 1 | 1 = irq from full, 0 = irq from ready |
| auto_rts | input | 1 | Enable automatic flow control |
| start_det | input | 1 | Pulse: valid start bit detected |
| char_valid | input | 1 | Pulse: character assembled |
| char_data | input | DW | Character value |
| char_err | input | 3 | Tags: bit0 parity, bit1 framing, bit2 break |
| rd_strobe | input | 1 | Host read of the data port |
| rd_data | output | DW | Last character read |
| stat_ready | output | 1 | At least one character queued |
| stat_full | output | 1 | All slots used |
| stat_err | output | 3 | Error tags per the selected mode |
| stat_ovr | output | 1 | Overrun flag |
| irq | output | 1 | Interrupt request |
| rts | output | 1 | Flow control, 1 = ready to receive |

## Verification
Directed sequences fill the queue to exactly three characters, then four (one waiting), then five. This separates a waiting character that is kept from one that is overwritten, and shows when the overrun flag sets relative to start pulses. Block-mode runs give characters with different tags. A pure head-tag display cannot then be mistaken for an accumulated OR. An empty-read case shows that a stray pop would change rd_data. A long pseudo-random sweep then runs through every combination of the three mode pins. It mixes arrivals, reads, start pulses, error clears, receiver resets and enable changes against a cycle model built from the requirements.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef logic [2:0] rx_err_t;
  localparam int ERR_PAR = 0;
  localparam int ERR_FRM = 1;
  localparam int ERR_BRK = 2;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 3,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  rx_err_t       push_flags,
  input  logic          pop,
  output logic [CW-1:0] count,
  output logic          full,
  output logic [DW-1:0] head_data,
  output rx_err_t       head_flags,
  output rx_err_t       next_flags
);
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [DW-1:0] slot_d [DEPTH];
  rx_err_t       slot_f [DEPTH];

  function automatic logic [PW-1:0] adv(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        slot_d[i] <= '0;
        slot_f[i] <= '0;
      end
    end else if (push && !clr) begin
      slot_d[wr_ptr] <= push_data;
      slot_f[wr_ptr] <= push_flags;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= adv(wr_ptr);
      if (pop)  rd_ptr <= adv(rd_ptr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign full       = (count == CW'(DEPTH));
  assign head_data  = slot_d[rd_ptr];
  assign head_flags = slot_f[rd_ptr];
  assign next_flags = slot_f[adv(rd_ptr)];

  // R4: the shift stage never pushes into a full queue unless a slot frees
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop && !clr) |-> !push);
  // R12: a pop never reaches an empty queue
  p_no_underflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));
endmodule

// File: rtl/rxq_hold.sv
module rxq_hold
  import rxq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          accept,
  input  logic [DW-1:0] in_data,
  input  rx_err_t       in_flags,
  input  logic          start_det,
  input  logic          fifo_full,
  input  logic          pop,
  output logic          push,
  output logic [DW-1:0] push_data,
  output rx_err_t       push_flags,
  output logic          hold_valid,
  output logic          ovr_set
);
  logic [DW-1:0] h_d;
  rx_err_t       h_f;
  logic          space;

  assign space   = !fifo_full || pop;
  assign ovr_set = start_det && hold_valid && !space;

  always_comb begin
    if (hold_valid) begin
      push       = space;
      push_data  = h_d;
      push_flags = h_f;
    end else begin
      push       = accept && space;
      push_data  = in_data;
      push_flags = in_flags;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_valid <= 1'b0;
      h_d        <= '0;
      h_f        <= '0;
    end else if (clr) begin
      hold_valid <= 1'b0;
    end else if (accept && (hold_valid || !space)) begin
      hold_valid <= 1'b1;
      h_d        <= in_data;
      h_f        <= in_flags;
    end else if (hold_valid && space) begin
      hold_valid <= 1'b0;
    end
  end

  // R4: a character only waits in the shift stage while the queue is full
  p_hold_when_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hold_valid |-> fifo_full);
endmodule

// File: rtl/rxq_status.sv
module rxq_status
  import rxq_pkg::*;
#(
  parameter int DEPTH = 3,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          err_clr,
  input  logic          block_mode,
  input  logic          irq_on_full,
  input  logic          auto_rts,
  input  logic          start_det,
  input  logic [CW-1:0] count,
  input  logic          full,
  input  logic          push,
  input  logic          pop,
  input  rx_err_t       head_flags,
  input  rx_err_t       next_flags,
  input  rx_err_t       push_flags,
  input  logic          ovr_set,
  output rx_err_t       stat_err,
  output logic          stat_ovr,
  output logic          ready,
  output logic          irq,
  output logic          rts
);
  logic [CW-1:0] count_next;
  logic          arrive;
  rx_err_t       arrive_flags, acc, char_flags;

  assign count_next   = count + CW'(push) - CW'(pop);
  assign arrive       = ((count == '0) || pop) && (count_next != '0);
  assign arrive_flags = (pop && count >= CW'(2)) ? next_flags : push_flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc      <= '0;
      stat_ovr <= 1'b0;
      rts      <= 1'b1;
    end else if (clr) begin
      acc      <= '0;
      stat_ovr <= 1'b0;
      rts      <= 1'b1;
    end else begin
      acc      <= (err_clr ? rx_err_t'(0) : acc) | (arrive ? arrive_flags : rx_err_t'(0));
      stat_ovr <= ovr_set | (stat_ovr & !err_clr);
      if (!auto_rts)                       rts <= 1'b1;
      else if (start_det && full && !pop)  rts <= 1'b0;
      else if (count_next < CW'(DEPTH))    rts <= 1'b1;
    end
  end

  assign char_flags = (count != '0) ? head_flags : '0;
  assign stat_err   = block_mode ? acc : char_flags;
  assign ready      = (count != '0);
  assign irq        = irq_on_full ? full : ready;

  // R9: a start bit seen on a full, unread queue drops rts
  p_rts_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts && start_det && full && !pop && !clr) |=> !rts);
  // R8: accumulated tags never lose a bit without a clear command
  p_block_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_clr && !clr) |=> ((acc & $past(acc)) == $past(acc)));
endmodule

// File: rtl/rx_char_fifo.sv
module rx_char_fifo
  import rxq_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en_cmd,
  input  logic          rx_dis_cmd,
  input  logic          rx_reset,
  input  logic          err_reset,
  input  logic          block_mode,
  input  logic          irq_on_full,
  input  logic          auto_rts,
  input  logic          start_det,
  input  logic          char_valid,
  input  logic [DW-1:0] char_data,
  input  logic [2:0]    char_err,
  input  logic          rd_strobe,
  output logic [DW-1:0] rd_data,
  output logic          stat_ready,
  output logic          stat_full,
  output logic [2:0]    stat_err,
  output logic          stat_ovr,
  output logic          irq,
  output logic          rts
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          rx_on, accept, pop, push, hold_valid, ovr_set, full;
  logic [CW-1:0] count;
  logic [DW-1:0] head_data, push_data;
  rx_err_t       head_flags, next_flags, push_flags;

  assign pop    = rd_strobe && (count != '0) && !rx_reset;
  assign accept = char_valid && rx_on && !rx_reset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rx_on <= 1'b0;
    else if (rx_reset)   rx_on <= 1'b0;
    else if (rx_en_cmd)  rx_on <= 1'b1;
    else if (rx_dis_cmd) rx_on <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rd_data <= '0;
    else if (pop) rd_data <= head_data;
  end

  rxq_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .clr(rx_reset), .accept(accept),
    .in_data(char_data), .in_flags(char_err), .start_det(start_det),
    .fifo_full(full), .pop(pop), .push(push), .push_data(push_data),
    .push_flags(push_flags), .hold_valid(hold_valid), .ovr_set(ovr_set)
  );

  rxq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(rx_reset), .push(push),
    .push_data(push_data), .push_flags(push_flags), .pop(pop),
    .count(count), .full(full), .head_data(head_data),
    .head_flags(head_flags), .next_flags(next_flags)
  );

  rxq_status #(.DEPTH(DEPTH)) u_status (
    .clk(clk), .rst_n(rst_n), .clr(rx_reset), .err_clr(err_reset),
    .block_mode(block_mode), .irq_on_full(irq_on_full), .auto_rts(auto_rts),
    .start_det(start_det), .count(count), .full(full), .push(push),
    .pop(pop), .head_flags(head_flags), .next_flags(next_flags),
    .push_flags(push_flags), .ovr_set(ovr_set), .stat_err(stat_err),
    .stat_ovr(stat_ovr), .ready(stat_ready), .irq(irq), .rts(rts)
  );

  assign stat_full = full;

  // R11: a receiver reset leaves everything idle on the next cycle
  p_rx_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_reset |=> (!stat_ready && !stat_ovr && rts && !irq));
  // R12: reading an empty queue keeps the last value
  p_empty_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !stat_ready) |=> $stable(rd_data));
  // R10: with the receiver off and nothing waiting, an arrival cannot fill an empty queue
  p_off_ignores_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_on && !hold_valid && !stat_ready) |=> !stat_ready);
endmodule

// File: tb/rx_char_fifo_bench.sv
module rx_char_fifo_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_en_cmd = 0, rx_dis_cmd = 0, rx_reset = 0, err_reset = 0;
  logic block_mode = 0, irq_on_full = 0, auto_rts = 0, start_det = 0;
  logic char_valid = 0, rd_strobe = 0;
  logic [7:0] char_data = '0;
  logic [2:0] char_err = '0;
  logic [7:0] rd_data;
  logic stat_ready, stat_full, stat_ovr, irq, rts;
  logic [2:0] stat_err;

  int n_cmp = 0, n_bad = 0;

  // reference model state
  int m_cnt = 0;
  logic [7:0] m_d [3];
  logic [2:0] m_f [3];
  logic m_hv = 0, m_ovr = 0, m_rts = 1, m_on = 0;
  logic [7:0] m_hd = 0, m_rdd = 0;
  logic [2:0] m_hf = 0, m_acc = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_char_fifo u_rx_char_fifo (
    .clk(clk), .rst_n(rst_n), .rx_en_cmd(rx_en_cmd), .rx_dis_cmd(rx_dis_cmd),
    .rx_reset(rx_reset), .err_reset(err_reset), .block_mode(block_mode),
    .irq_on_full(irq_on_full), .auto_rts(auto_rts), .start_det(start_det),
    .char_valid(char_valid), .char_data(char_data), .char_err(char_err),
    .rd_strobe(rd_strobe), .rd_data(rd_data), .stat_ready(stat_ready),
    .stat_full(stat_full), .stat_err(stat_err), .stat_ovr(stat_ovr),
    .irq(irq), .rts(rts)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic m_push(input logic [7:0] d, input logic [2:0] f);
    m_d[m_cnt] = d;
    m_f[m_cnt] = f;
    m_cnt++;
  endtask

  task automatic check_all();
    chk("R3 ready", 32'(stat_ready), 32'(m_cnt > 0));
    chk("R3 full", 32'(stat_full), 32'(m_cnt == 3));
    chk("R3 irq", 32'(irq), irq_on_full ? 32'(m_cnt == 3) : 32'(m_cnt > 0));
    if (block_mode) chk("R8 stat_err", 32'(stat_err), 32'(m_acc));
    else            chk("R7 stat_err", 32'(stat_err), (m_cnt > 0) ? 32'(m_f[0]) : 32'd0);
    chk("R6 ovr", 32'(stat_ovr), 32'(m_ovr));
    chk("R9 rts", 32'(rts), 32'(m_rts));
    chk("R2 rd_data", 32'(rd_data), 32'(m_rdd));
  endtask

  // one cycle of stimulus, model update, then compare after the edge
  task automatic step(input logic cv, input logic [7:0] cd, input logic [2:0] cf,
                      input logic sd, input logic rd, input logic er,
                      input logic rr, input logic en, input logic dis);
    logic pop, full, space, accept, arrive;
    logic [2:0] acc_base;
    int old;
    char_valid = cv; char_data = cd; char_err = cf; start_det = sd;
    rd_strobe = rd; err_reset = er; rx_reset = rr; rx_en_cmd = en; rx_dis_cmd = dis;
    if (rr) begin
      m_cnt = 0; m_hv = 0; m_acc = 0; m_ovr = 0; m_rts = 1; m_on = 0;
    end else begin
      old      = m_cnt;
      pop      = rd && (m_cnt > 0);
      full     = (m_cnt == 3);
      space    = !full || pop;
      acc_base = er ? 3'b000 : m_acc;
      m_ovr    = (sd && m_hv && !space) || (m_ovr && !er);
      if (pop) begin
        m_rdd = m_d[0];
        m_d[0] = m_d[1]; m_f[0] = m_f[1];
        m_d[1] = m_d[2]; m_f[1] = m_f[2];
        m_cnt--;
      end
      accept = cv && m_on;
      if (m_hv) begin
        if (space) m_push(m_hd, m_hf);
        if (accept) begin m_hd = cd; m_hf = cf; m_hv = 1; end
        else m_hv = !space;
      end else if (accept) begin
        if (space) m_push(cd, cf);
        else begin m_hd = cd; m_hf = cf; m_hv = 1; end
      end
      arrive = ((old == 0) || pop) && (m_cnt > 0);
      m_acc  = acc_base | (arrive ? m_f[0] : 3'b000);
      if (!auto_rts) m_rts = 1;
      else if (sd && full && !pop) m_rts = 0;
      else if (m_cnt < 3) m_rts = 1;
      if (en) m_on = 1;
      else if (dis) m_on = 0;
    end
    @(negedge clk);
    char_valid = 0; start_det = 0; rd_strobe = 0; err_reset = 0;
    rx_reset = 0; rx_en_cmd = 0; rx_dis_cmd = 0;
    check_all();
  endtask

  task automatic put(input logic [7:0] d, input logic [2:0] f, input logic sd);
    step(1, d, f, sd, 0, 0, 0, 0, 0);
  endtask
  task automatic take();
    step(0, 0, 0, 0, 1, 0, 0, 0, 0);
  endtask
  task automatic idle(input logic sd, input logic er, input logic rr, input logic en, input logic dis);
    step(0, 0, 0, sd, 0, er, rr, en, dis);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", 32'(stat_ready), 0);
    chk("R1 full", 32'(stat_full), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 ovr", 32'(stat_ovr), 0);
    chk("R1 err", 32'(stat_err), 0);
    chk("R1 rts", 32'(rts), 1);
    chk("R1 rd_data", 32'(rd_data), 0);

    auto_rts = 1;
    idle(0, 0, 0, 1, 0);
    put(8'h11, 3'b001, 0);
    chk("R7 head tag parity", 32'(stat_err), 32'h1);
    put(8'h22, 3'b010, 0);
    put(8'h33, 3'b100, 0);
    chk("R3 full after three", 32'(stat_full), 1);
    put(8'h44, 3'b000, 1);               // start seen while full
    chk("R9 rts dropped", 32'(rts), 0);
    chk("R6 no overrun on fourth", 32'(stat_ovr), 0);
    take();
    chk("R2 first out", 32'(rd_data), 32'h11);
    chk("R4 held moves in, still full", 32'(stat_full), 1);
    chk("R9 rts still low", 32'(rts), 0);
    take();
    chk("R2 second out", 32'(rd_data), 32'h22);
    chk("R9 rts back", 32'(rts), 1);
    take();
    take();
    chk("R4 fourth char kept", 32'(rd_data), 32'h44);
    chk("R3 empty", 32'(stat_ready), 0);

    // R5/R6 overwrite of the waiting character
    put(8'h01, 0, 0); put(8'h02, 0, 0); put(8'h03, 0, 0);
    put(8'hAA, 0, 0);
    idle(1, 0, 0, 0, 0);
    chk("R6 overrun on start", 32'(stat_ovr), 1);
    put(8'hBB, 0, 0);
    take(); take(); take();
    chk("R5 queue unchanged", 32'(rd_data), 32'h03);
    take();
    chk("R5 waiting char replaced", 32'(rd_data), 32'hBB);
    idle(0, 1, 0, 0, 0);
    chk("R8 err_reset clears ovr", 32'(stat_ovr), 0);

    take();
    chk("R12 empty read keeps data", 32'(rd_data), 32'hBB);
    chk("R12 still empty", 32'(stat_ready), 0);

    // R10 disabled receiver
    idle(0, 0, 0, 0, 1);
    put(8'h55, 0, 0);
    chk("R10 ignored while off", 32'(stat_ready), 0);
    idle(0, 0, 0, 1, 0);
    put(8'h66, 0, 0);
    idle(0, 0, 0, 0, 1);
    take();
    chk("R10 read while off", 32'(rd_data), 32'h66);

    // R11 receiver reset
    idle(0, 0, 0, 1, 0);
    put(8'h77, 3'b011, 0); put(8'h78, 0, 0);
    idle(0, 0, 1, 0, 0);
    chk("R11 queue cleared", 32'(stat_ready), 0);
    chk("R11 err cleared", 32'(stat_err), 0);
    put(8'h79, 0, 0);
    chk("R11 off until enabled", 32'(stat_ready), 0);
    idle(0, 0, 0, 1, 0);
    put(8'h7A, 0, 0);
    take();
    chk("R11 re-enabled", 32'(rd_data), 32'h7A);

    // R8 block accumulation
    block_mode = 1;
    idle(0, 1, 0, 0, 0);
    put(8'h81, 3'b001, 0); put(8'h82, 3'b010, 0);
    chk("R8 only head so far", 32'(stat_err), 32'h1);
    take();
    chk("R8 OR after second reaches head", 32'(stat_err), 32'h3);
    take();
    chk("R8 sticky when empty", 32'(stat_err), 32'h3);
    idle(0, 1, 0, 0, 0);
    chk("R8 cleared", 32'(stat_err), 0);

    // sweep across all mode combinations
    for (int cfg = 0; cfg < 8; cfg++) begin
      block_mode = cfg[0]; irq_on_full = cfg[1]; auto_rts = cfg[2];
      idle(0, 0, 1, 0, 0);
      idle(0, 1, 0, 1, 0);
      for (int k = 0; k < 600; k++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        step(lfsr[0], lfsr[15:8] ^ 8'(k), lfsr[7:5], lfsr[1],
             lfsr[2] & lfsr[3], (lfsr[4:1] == 4'hF), (lfsr[9:3] == 7'h55),
             lfsr[11], (lfsr[14:11] == 4'h0));
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule